// File: doc/BRIEF.md
# Secured OTP Region Access Mode Controller

This block sits in a serial flash target between the command decoder and the array select. It routes the normal byte read, byte program and erase commands either to the main array or to a separate 512-byte one-time-programmable (OTP) region. Two mode commands pick the region: `B1h` switches to the OTP region and `C1h` switches back. While the OTP region is selected, the main array cannot be reached at all.

A security register reports lock and failure state. It is read with `2Bh` and written with `2Fh`. Writing it can only set the user lock-down bit, which makes the OTP region permanently read-only. A factory lock strap sets its own sticky bit, and that bit also locks the region. Lock bits stand in for non-volatile cells and are cleared only by power-on reset. The decoder is modelled as a one-cycle command strobe, and both arrays are modelled as small byte stores in which programming can only clear bits.

Top module: `otp_access_top`

## Requirements
- R1: After reset the block is in main-array mode (`otp_sel`=0), `wel`=0, `rd_valid`=0, every byte of both arrays reads FFh, and the security register reads 00h while `factory_lock` is low.
- R2: A command `B1h` sets `otp_sel` to 1, and a command `C1h` clears it. The new value is visible in the cycle after the command.
- R3: A read `03h` asserts `rd_valid` for one cycle, in the cycle after the command. `rd_data` then carries the addressed byte of the OTP region when `otp_sel`=1, and of the main array otherwise. The main array is never returned while `otp_sel`=1.
- R4: `06h` sets `wel` and `04h` clears it. `02h`, `20h` and `2Fh` each clear `wel`. A program `02h` issued with `wel`=1 ANDs `cmd_data` into the addressed byte of the selected region. Issued with `wel`=0, it changes nothing.
- R5: The OTP byte index is `cmd_addr` modulo 512, and the main-array index is `cmd_addr` modulo `MAIN_BYTES` (64 by default).
- R6: A read `2Bh` returns the security register on `rd_data` with the `03h` timing. The fields are: bit 0 factory lock, bit 1 user lock-down, bit 5 program failure, bit 6 erase failure. All other bits are 0.
- R7: `2Fh` with `wel`=1 and `cmd_data[1]`=1 sets the lock-down bit. No command clears it. `2Fh` with `wel`=0 changes nothing.
- R8: When either lock bit is set, a program with `wel`=1 in OTP mode leaves the OTP region unchanged and sets the program-failure bit. The next successful program clears that bit.
- R9: `20h` with `wel`=1 in main mode sets every main byte to FFh and clears the erase-failure bit. In OTP mode it erases nothing and sets the erase-failure bit.
- R10: A high `factory_lock` in any cycle sets security bit 0, which stays set until reset and locks the OTP region.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low power-on reset |
| cmd_valid | input | 1 | One-cycle strobe for a decoded command |
| cmd_op | input | 8 | Command opcode |
| cmd_addr | input | ADDR_W | Byte address of the command |
| cmd_data | input | 8 | Program data or security register write data |
| factory_lock | input | 1 | Factory lock strap, captured as a sticky bit |
| otp_sel | output | 1 | 1 = OTP region selected, 0 = main array |
| wel | output | 1 | Write enable latch |
| rd_valid | output | 1 | Read data valid |
| rd_data | output | 8 | Read data |

## Verification
The same addresses are read and programmed in both modes. This shows that the mode really redirects each access and never leaks main-array contents into OTP reads. Addresses just past 512 and past the main depth show wrap-around apart from plain aliasing.

Programs and register writes are issued with and without the write latch, and before and after lock-down or factory lock. This separates a program that is accepted, one that is ignored silently, and one that is rejected with a failure flag. Erase in each mode separates the erase that succeeds from the one that is refused.

// File: rtl/otp_pkg.sv
package otp_pkg;
  localparam logic [7:0] OP_READ  = 8'h03;
  localparam logic [7:0] OP_PROG  = 8'h02;
  localparam logic [7:0] OP_ERASE = 8'h20;
  localparam logic [7:0] OP_WREN  = 8'h06;
  localparam logic [7:0] OP_WRDI  = 8'h04;
  localparam logic [7:0] OP_ENTER = 8'hB1;
  localparam logic [7:0] OP_EXIT  = 8'hC1;
  localparam logic [7:0] OP_RDSEC = 8'h2B;
  localparam logic [7:0] OP_WRSEC = 8'h2F;

  typedef struct packed {
    logic efail;
    logic pfail;
    logic lock;
    logic fact;
  } sec_t;

  function automatic logic [7:0] sec_byte(sec_t s);
    return {1'b0, s.efail, s.pfail, 3'b000, s.lock, s.fact};
  endfunction
endpackage

// File: rtl/otp_byte_store.sv
module otp_byte_store #(
  parameter int DEPTH = 512,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic          clr_all,
  input  logic [AW-1:0] addr,
  input  logic [7:0]    wdata,
  output logic [7:0]    rdata
);
  logic [7:0] cell_q [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : g_cell
    logic hit;
    assign hit = wr_en && (addr == AW'(g));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       cell_q[g] <= 8'hFF;
      else if (clr_all) cell_q[g] <= 8'hFF;
      else if (hit)     cell_q[g] <= cell_q[g] & wdata;
    end
  end

  assign rdata = cell_q[addr];
endmodule

// File: rtl/otp_mode_ctrl.sv
module otp_mode_ctrl
  import otp_pkg::*;
#(
  parameter int ADDR_W     = 24,
  parameter int OTP_BYTES  = 512,
  parameter int MAIN_BYTES = 64,
  localparam int OTP_AW  = $clog2(OTP_BYTES),
  localparam int MAIN_AW = $clog2(MAIN_BYTES)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cmd_valid,
  input  logic [7:0]         cmd_op,
  input  logic [ADDR_W-1:0]  cmd_addr,
  input  logic [7:0]         cmd_data,
  input  logic               factory_lock,
  input  logic [7:0]         otp_rdata_i,
  input  logic [7:0]         main_rdata_i,
  output logic [OTP_AW-1:0]  otp_idx_o,
  output logic [MAIN_AW-1:0] main_idx_o,
  output logic               prog_otp_o,
  output logic               prog_main_o,
  output logic               erase_main_o,
  output logic               otp_sel_o,
  output logic               wel_o,
  output logic               rd_valid_o,
  output logic [7:0]         rd_data_o
);
  logic       otp_mode_q, otp_mode_d;
  logic       wel_q, wel_d;
  sec_t       sec_q, sec_d;
  logic       rd_valid_q, rd_valid_d;
  logic [7:0] rd_data_q, rd_data_d;
  logic       locked;

  assign otp_idx_o  = OTP_AW'(cmd_addr % ADDR_W'(OTP_BYTES));
  assign main_idx_o = MAIN_AW'(cmd_addr % ADDR_W'(MAIN_BYTES));
  assign locked     = sec_q.fact | sec_q.lock;

  always_comb begin
    otp_mode_d   = otp_mode_q;
    wel_d        = wel_q;
    sec_d        = sec_q;
    sec_d.fact   = sec_q.fact | factory_lock;
    rd_valid_d   = 1'b0;
    rd_data_d    = rd_data_q;
    prog_otp_o   = 1'b0;
    prog_main_o  = 1'b0;
    erase_main_o = 1'b0;
    if (cmd_valid) begin
      case (cmd_op)
        OP_WREN:  wel_d = 1'b1;
        OP_WRDI:  wel_d = 1'b0;
        OP_ENTER: otp_mode_d = 1'b1;
        OP_EXIT:  otp_mode_d = 1'b0;
        OP_READ: begin
          rd_valid_d = 1'b1;
          rd_data_d  = otp_mode_q ? otp_rdata_i : main_rdata_i;
        end
        OP_RDSEC: begin
          rd_valid_d = 1'b1;
          rd_data_d  = sec_byte(sec_q);
        end
        OP_PROG: begin
          wel_d = 1'b0;
          if (wel_q) begin
            if (otp_mode_q && locked) begin
              sec_d.pfail = 1'b1;
            end else begin
              sec_d.pfail = 1'b0;
              prog_otp_o  = otp_mode_q;
              prog_main_o = !otp_mode_q;
            end
          end
        end
        OP_ERASE: begin
          wel_d = 1'b0;
          if (wel_q) begin
            sec_d.efail  = otp_mode_q;
            erase_main_o = !otp_mode_q;
          end
        end
        OP_WRSEC: begin
          wel_d = 1'b0;
          if (wel_q && cmd_data[1]) sec_d.lock = 1'b1;
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      otp_mode_q <= 1'b0;
      wel_q      <= 1'b0;
      sec_q      <= '0;
      rd_valid_q <= 1'b0;
      rd_data_q  <= 8'h00;
    end else begin
      otp_mode_q <= otp_mode_d;
      wel_q      <= wel_d;
      sec_q      <= sec_d;
      rd_valid_q <= rd_valid_d;
      if (rd_valid_d) rd_data_q <= rd_data_d;
    end
  end

  assign otp_sel_o  = otp_mode_q;
  assign wel_o      = wel_q;
  assign rd_valid_o = rd_valid_q;
  assign rd_data_o  = rd_data_q;

  // R2
  enter_only_by_cmd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(otp_mode_q) |-> $past(cmd_valid && cmd_op == OP_ENTER));

  // R3
  rd_follows_cmd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid_q |-> $past(cmd_valid && (cmd_op == OP_READ || cmd_op == OP_RDSEC)));

  // R7
  lock_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$fell(sec_q.lock));

  // R7
  lock_needs_wel_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sec_q.lock) |-> $past(wel_q));

  // R8
  locked_prog_fails_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_op == OP_PROG && wel_q && otp_mode_q && locked) |=> sec_q.pfail);

  // R10
  fact_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$fell(sec_q.fact));
endmodule

// File: rtl/otp_access_top.sv
module otp_access_top #(
  parameter int ADDR_W     = 24,
  parameter int OTP_BYTES  = 512,
  parameter int MAIN_BYTES = 64,
  localparam int OTP_AW  = $clog2(OTP_BYTES),
  localparam int MAIN_AW = $clog2(MAIN_BYTES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  input  logic [7:0]        cmd_op,
  input  logic [ADDR_W-1:0] cmd_addr,
  input  logic [7:0]        cmd_data,
  input  logic              factory_lock,
  output logic              otp_sel,
  output logic              wel,
  output logic              rd_valid,
  output logic [7:0]        rd_data
);
  logic [OTP_AW-1:0]  otp_idx;
  logic [MAIN_AW-1:0] main_idx;
  logic [7:0]         otp_rdata, main_rdata;
  logic               prog_otp, prog_main, erase_main;

  otp_mode_ctrl #(
    .ADDR_W(ADDR_W), .OTP_BYTES(OTP_BYTES), .MAIN_BYTES(MAIN_BYTES)
  ) u_ctrl (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
    .cmd_addr(cmd_addr), .cmd_data(cmd_data), .factory_lock(factory_lock),
    .otp_rdata_i(otp_rdata), .main_rdata_i(main_rdata),
    .otp_idx_o(otp_idx), .main_idx_o(main_idx),
    .prog_otp_o(prog_otp), .prog_main_o(prog_main), .erase_main_o(erase_main),
    .otp_sel_o(otp_sel), .wel_o(wel), .rd_valid_o(rd_valid), .rd_data_o(rd_data)
  );

  otp_byte_store #(.DEPTH(OTP_BYTES)) u_otp (
    .clk(clk), .rst_n(rst_n), .wr_en(prog_otp), .clr_all(1'b0),
    .addr(otp_idx), .wdata(cmd_data), .rdata(otp_rdata)
  );

  otp_byte_store #(.DEPTH(MAIN_BYTES)) u_main (
    .clk(clk), .rst_n(rst_n), .wr_en(prog_main), .clr_all(erase_main),
    .addr(main_idx), .wdata(cmd_data), .rdata(main_rdata)
  );
endmodule

// File: tb/otp_access_top_test.sv
module otp_access_top_test;
  localparam int AW = 24;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          cmd_valid = 1'b0;
  logic [7:0]    cmd_op = 8'h00;
  logic [AW-1:0] cmd_addr = '0;
  logic [7:0]    cmd_data = 8'h00;
  logic          factory_lock = 1'b0;
  logic          otp_sel, wel, rd_valid;
  logic [7:0]    rd_data;

  int checks = 0;
  int errors = 0;
  string cur_tag = "R1";

  otp_access_top uut (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
    .cmd_addr(cmd_addr), .cmd_data(cmd_data), .factory_lock(factory_lock),
    .otp_sel(otp_sel), .wel(wel), .rd_valid(rd_valid), .rd_data(rd_data)
  );

  always #10 clk = ~clk;

  // behavioural reference
  int    m_otp [512];
  int    m_main [64];
  bit    m_mode, m_wel, m_fact, m_lock, m_pf, m_ef, m_rv;
  int    m_rd;
  string m_tag;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      foreach (m_otp[i]) m_otp[i] = 255;
      foreach (m_main[i]) m_main[i] = 255;
      m_mode = 0; m_wel = 0; m_fact = 0; m_lock = 0; m_pf = 0; m_ef = 0; m_rv = 0;
      m_rd = 0; m_tag = "R1";
    end else begin
      bit lk;
      int oi, mi;
      lk = m_fact || m_lock;
      oi = int'(cmd_addr) % 512;
      mi = int'(cmd_addr) % 64;
      m_rv = 0;
      if (cmd_valid) begin
        case (cmd_op)
          8'h06: m_wel = 1;
          8'h04: m_wel = 0;
          8'hB1: m_mode = 1;
          8'hC1: m_mode = 0;
          8'h03: begin m_rv = 1; m_tag = cur_tag; m_rd = m_mode ? m_otp[oi] : m_main[mi]; end
          8'h2B: begin
            m_rv = 1; m_tag = cur_tag;
            m_rd = (m_fact ? 1 : 0) + (m_lock ? 2 : 0) + (m_pf ? 32 : 0) + (m_ef ? 64 : 0);
          end
          8'h02: begin
            if (m_wel) begin
              if (m_mode && lk) m_pf = 1;
              else begin
                m_pf = 0;
                if (m_mode) m_otp[oi] = m_otp[oi] & int'(cmd_data);
                else m_main[mi] = m_main[mi] & int'(cmd_data);
              end
            end
            m_wel = 0;
          end
          8'h20: begin
            if (m_wel) begin
              if (m_mode) m_ef = 1;
              else begin m_ef = 0; foreach (m_main[i]) m_main[i] = 255; end
            end
            m_wel = 0;
          end
          8'h2F: begin
            if (m_wel && cmd_data[1]) m_lock = 1;
            m_wel = 0;
          end
          default: ;
        endcase
      end
      if (factory_lock) m_fact = 1;
    end
  end

  task automatic chk(string tag, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n) begin
      chk(m_tag == "R1" ? "R1" : "R2", "otp_sel", int'(otp_sel), int'(m_mode));
      chk(m_tag == "R1" ? "R1" : "R4", "wel", int'(wel), int'(m_wel));
      chk(m_tag == "R1" ? "R1" : "R3", "rd_valid", int'(rd_valid), int'(m_rv));
      if (m_rv) chk(m_tag, "rd_data", int'(rd_data), m_rd);
    end
  end

  task automatic cmd(logic [7:0] op, int addr, logic [7:0] data, string tag);
    @(negedge clk);
    cur_tag = tag; cmd_valid = 1'b1; cmd_op = op; cmd_addr = AW'(addr); cmd_data = data;
    @(negedge clk);
    cmd_valid = 1'b0;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual hung expected done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    do_reset();
    cmd(8'h03, 5, 0, "R1");
    cmd(8'h2B, 0, 0, "R1");
    cmd(8'h02, 5, 8'h00, "R4");           // no latch: ignored
    cmd(8'h03, 5, 0, "R4");
    cmd(8'h06, 0, 0, "R4");
    cmd(8'h02, 5, 8'hA5, "R4");
    cmd(8'h03, 5, 0, "R4");
    cmd(8'hB1, 0, 0, "R2");
    cmd(8'h03, 5, 0, "R3");               // main hidden
    cmd(8'h06, 0, 0, "R4");
    cmd(8'h02, 5, 8'h3C, "R3");
    cmd(8'h03, 5, 0, "R3");
    cmd(8'h03, 517, 0, "R5");
    cmd(8'h06, 0, 0, "R5");
    cmd(8'h02, 519, 8'h5A, "R5");
    cmd(8'h03, 7, 0, "R5");
    cmd(8'hC1, 0, 0, "R2");
    cmd(8'h03, 5, 0, "R3");
    cmd(8'h03, 69, 0, "R5");
    cmd(8'h03, 7, 0, "R3");
    cmd(8'h06, 0, 0, "R9");
    cmd(8'h20, 0, 0, "R9");
    cmd(8'h03, 5, 0, "R9");
    cmd(8'h2B, 0, 0, "R9");
    cmd(8'hB1, 0, 0, "R2");
    cmd(8'h06, 0, 0, "R9");
    cmd(8'h20, 0, 0, "R9");
    cmd(8'h2B, 0, 0, "R9");
    cmd(8'h03, 5, 0, "R9");
    cmd(8'h2F, 0, 8'h02, "R7");           // no latch
    cmd(8'h2B, 0, 0, "R7");
    cmd(8'h06, 0, 0, "R7");
    cmd(8'h2F, 0, 8'h02, "R7");
    cmd(8'h2B, 0, 0, "R6");
    cmd(8'h06, 0, 0, "R7");
    cmd(8'h2F, 0, 8'h00, "R7");
    cmd(8'h2B, 0, 0, "R7");
    cmd(8'h06, 0, 0, "R8");
    cmd(8'h02, 9, 8'h00, "R8");
    cmd(8'h2B, 0, 0, "R8");
    cmd(8'h03, 9, 0, "R8");
    cmd(8'hC1, 0, 0, "R2");
    cmd(8'h06, 0, 0, "R8");
    cmd(8'h02, 1, 8'h0F, "R8");
    cmd(8'h2B, 0, 0, "R8");
    cmd(8'h03, 1, 0, "R8");
    do_reset();
    cmd(8'h2B, 0, 0, "R1");
    cmd(8'h03, 1, 0, "R1");
    @(negedge clk); factory_lock = 1'b1;
    @(negedge clk); factory_lock = 1'b0;
    cmd(8'h2B, 0, 0, "R10");
    cmd(8'hB1, 0, 0, "R2");
    cmd(8'h06, 0, 0, "R10");
    cmd(8'h02, 3, 8'h00, "R10");
    cmd(8'h03, 3, 0, "R10");
    cmd(8'h2B, 0, 0, "R10");
    repeat (3) @(negedge clk);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule